// File: doc/BRIEF.md
# Nested signed-digit constant multiplier

This block multiplies a signed sample by a coefficient that is stored as a short chain of signed-digit records instead of a binary word. There are three records, one per pipeline stage. Each record holds a small shift field, a sign and a skip flag. Each stage adds the sample to the running value, or subtracts it, or passes the value unchanged, and then shifts the result right. Because the shifts are nested in Horner order, every record carries only the distance to the next digit. The shift fields therefore stay at one or two bits.

The running value is kept in fixed point with `FRAC` fractional bits. The right shift is arithmetic, with one correction: a result of exactly minus one LSB is replaced by zero, which removes the downward bias of plain truncation. The three stages are pipelined. A new sample and code pair can be presented on every cycle, and each product appears a fixed three cycles later. Summing products across filter taps is left to the surrounding logic.

Top module: `nsd_mult`

## Requirements
- R1: The 10-bit code holds three records. Bits [2:0] belong to stage 1, bits [5:3] to stage 2 and bits [9:6] to stage 3. Inside each record, the lowest bit is the skip flag, the next bit is the sign (1 means subtract) and the remaining bits are the shift field. The shift applied is the field value plus 2 for stage 1, plus 2 for stage 2 and plus 1 for stage 3.
- R2: Stage 1 starts from zero. Each stage adds the sample (or subtracts it, when the sign is 1) to the previous stage's value and then shifts right by its shift amount. `product` is the stage 3 value, scaled by 2^-FRAC. Its magnitude never exceeds 2^(XW-1)·2^FRAC.
- R3: When a record's skip flag is 1, that stage adds nothing but still applies its shift. When all three skip flags are 1, the product is 0.
- R4: Each right shift is arithmetic, so a negative value with discarded nonzero bits rounds toward minus infinity.
- R5: When a stage's shifted result equals minus one LSB (all bits 1), that stage's result is replaced by 0.
- R6: `out_valid` rises exactly three clock cycles after the cycle in which `in_valid` was sampled high, and only then. The block accepts one operation per cycle and returns the results in issue order.
- R7: While `rst_n` is low, `out_valid` and `product` are 0.
- R8: Code 0x122 (shifts 2, 3, 2; signs subtract, add, add) applied to sample 7 gives 1.9140625, which is 245 when FRAC=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Sample and code are valid this cycle |
| sample_in | input | XW | Signed sample |
| coef_in | input | 10 | Signed-digit coefficient code |
| out_valid | output | 1 | Product is valid |
| product | output | XW+FRAC+2 | Signed product, FRAC fractional bits |

## Verification
The pipeline has a finishing operation and a newly accepted one in flight at the same time. The sweep therefore issues operations on consecutive cycles, with an idle cycle inserted regularly. Every result must arrive exactly three cycles after its issue and in issue order. Within one operation, a skipped stage can produce the minus-one-LSB pattern that the bias correction must clear, and a negative value can lose nonzero bits in the same shift. Every pairing of record values with every sample value is compared against an integer model of the stage recurrence. Each mismatch is tagged with the requirement that its case exercises.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
    localparam int STAGES = 3;
    localparam int CODE_W = 10;
    // shift field width, shift offset and record position per stage
    localparam int SH_W    [STAGES] = '{1, 1, 2};
    localparam int SH_BASE [STAGES] = '{2, 2, 1};
    localparam int REC_LSB [STAGES] = '{0, 3, 6};
    localparam int REC1_W = SH_W[1] + 2;
    localparam int REC2_W = SH_W[2] + 2;
endpackage

// File: rtl/nsd_bias_shr.sv
module nsd_bias_shr #(
    parameter int W    = 16,
    parameter int SHW  = 1,
    parameter int BASE = 1
) (
    input  logic signed [W-1:0]   din,
    input  logic        [SHW-1:0] fld,
    output logic signed [W-1:0]   dout
);
    int                 amt;
    logic signed [W-1:0] shifted;

    always_comb begin
        amt     = int'(fld) + BASE;
        shifted = din >>> amt;
        // a lone negative LSB is cleared to cancel truncation bias
        if (shifted == {W{1'b1}}) dout = '0;
        else                      dout = shifted;
    end
endmodule

// File: rtl/nsd_stage.sv
module nsd_stage #(
    parameter int XW   = 8,
    parameter int FRAC = 7,
    parameter int P    = XW + FRAC + 2,
    parameter int SHW  = 1,
    parameter int BASE = 1
) (
    input  logic signed [P-1:0]   prev,
    input  logic signed [XW-1:0]  x,
    input  logic        [SHW+1:0] rec,
    output logic signed [P-1:0]   res
);
    logic signed [P-1:0] x_ext;
    logic signed [P-1:0] term;
    logic signed [P-1:0] sum;

    always_comb begin
        x_ext = {{(P-XW){x[XW-1]}}, x};
        term  = x_ext <<< FRAC;
        if (rec[0])      sum = prev;          // skip flag
        else if (rec[1]) sum = prev - term;   // subtract
        else             sum = prev + term;
    end

    nsd_bias_shr #(
        .W    (P),
        .SHW  (SHW),
        .BASE (BASE)
    ) u_shr (
        .din  (sum),
        .fld  (rec[SHW+1:2]),
        .dout (res)
    );
endmodule

// File: rtl/nsd_mult.sv
module nsd_mult #(
    parameter int XW   = 8,
    parameter int FRAC = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [XW-1:0]             sample_in,
    input  logic [nsd_pkg::CODE_W-1:0] coef_in,
    output logic                      out_valid,
    output logic [XW+FRAC+1:0]        product
);
    import nsd_pkg::*;

    localparam int P   = XW + FRAC + 2;
    localparam int LIM = 2 ** (XW - 1 + FRAC);

    typedef struct packed {
        logic [STAGES-1:0]               vld;
        logic [STAGES-1:0][P-1:0]        acc;
        logic [STAGES-2:0][XW-1:0]       x;
        logic [REC1_W-1:0]               rec1_a;  // stage 2 record after stage 1
        logic [REC2_W-1:0]               rec2_a;  // stage 3 record after stage 1
        logic [REC2_W-1:0]               rec2_b;  // stage 3 record after stage 2
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic signed [P-1:0]  stg_prev [STAGES];
    logic signed [P-1:0]  stg_res  [STAGES];
    logic signed [XW-1:0] stg_x    [STAGES];

    always_comb begin
        stg_prev[0] = '0;
        stg_x[0]    = sample_in;
        for (int k = 1; k < STAGES; k++) begin
            stg_prev[k] = pipe_q.acc[k-1];
            stg_x[k]    = pipe_q.x[k-1];
        end
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int RW = SH_W[k] + 2;
        logic [RW-1:0] rec;
        if (k == 0) begin : g_src0
            assign rec = coef_in[REC_LSB[0] +: RW];
        end else if (k == 1) begin : g_src1
            assign rec = pipe_q.rec1_a;
        end else begin : g_src2
            assign rec = pipe_q.rec2_b;
        end
        nsd_stage #(
            .XW   (XW),
            .FRAC (FRAC),
            .P    (P),
            .SHW  (SH_W[k]),
            .BASE (SH_BASE[k])
        ) u_stage (
            .prev (stg_prev[k]),
            .x    (stg_x[k]),
            .rec  (rec),
            .res  (stg_res[k])
        );
    end

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.vld    = {pipe_q.vld[STAGES-2:0], in_valid};
        for (int k = 0; k < STAGES; k++) pipe_d.acc[k] = stg_res[k];
        pipe_d.x[0]   = sample_in;
        for (int k = 1; k < STAGES - 1; k++) pipe_d.x[k] = pipe_q.x[k-1];
        pipe_d.rec1_a = coef_in[REC_LSB[1] +: REC1_W];
        pipe_d.rec2_a = coef_in[REC_LSB[2] +: REC2_W];
        pipe_d.rec2_b = pipe_q.rec2_a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.vld[STAGES-1];
    assign product   = pipe_q.acc[STAGES-1];

    // R6
    lat_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 out_valid);

    // R6
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##2 !out_valid);

    // R5
    no_lone_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (product != {P{1'b1}}));

    // R2
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($signed(product) <= LIM) && ($signed(product) >= -LIM)));

    // R3
    all_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && coef_in[REC_LSB[0]] && coef_in[REC_LSB[1]] && coef_in[REC_LSB[2]])
        |=> ##2 (product == '0));
endmodule

// File: tb/nsd_mult_tb.sv
module nsd_mult_tb;
    localparam int XW   = 6;
    localparam int FRAC = 7;
    localparam int P    = XW + FRAC + 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          in_valid;
    logic [XW-1:0] sample_in;
    logic [9:0]    coef_in;
    logic          out_valid;
    logic [P-1:0]  product;

    nsd_mult #(.XW(XW), .FRAC(FRAC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sample_in (sample_in),
        .coef_in   (coef_in),
        .out_valid (out_valid),
        .product   (product)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    exp_q[$];
    int    iss_q[$];
    string tag_q[$];

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R1 field layout, R2 recurrence, R3 skip, R4 floor shift, R5 bias clear
    function automatic int model(input int code, input int x, output string tag);
        int acc, lsb, shw, base, sh, fld;
        bit skip, neg, hit_bias, hit_floor, hit_skip;
        acc = 0; hit_bias = 0; hit_floor = 0; hit_skip = 0;
        for (int k = 0; k < 3; k++) begin
            lsb  = (k == 0) ? 0 : (k == 1) ? 3 : 6;
            shw  = (k == 2) ? 2 : 1;
            base = (k == 2) ? 1 : 2;
            skip = code[lsb];
            neg  = code[lsb+1];
            fld  = (code >> (lsb + 2)) & ((1 << shw) - 1);
            sh   = fld + base;
            if (skip) hit_skip = 1;
            else if (neg) acc = acc - x * (1 << FRAC);
            else acc = acc + x * (1 << FRAC);
            if (acc < 0 && (acc & ((1 << sh) - 1)) != 0) hit_floor = 1;
            acc = acc >>> sh;
            if (acc == -1) begin acc = 0; hit_bias = 1; end
        end
        if (hit_bias)       tag = "R1 R5";
        else if (hit_floor) tag = "R1 R4";
        else if (hit_skip)  tag = "R1 R3";
        else                tag = "R1 R2";
        return acc;
    endfunction

    task automatic issue(input int code, input int x, input string force_tag);
        string t;
        int e;
        e = model(code, x, t);
        if (force_tag != "") t = force_tag;
        in_valid  = 1'b1;
        sample_in = XW'(x);
        coef_in   = 10'(code);
        exp_q.push_back(e);
        iss_q.push_back(cyc);
        tag_q.push_back(t);
        @(posedge clk); #1;
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(posedge clk); #1;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected valid", 1, 0);
            end else begin
                int e, iss;
                string t;
                e   = exp_q.pop_front();
                iss = iss_q.pop_front();
                t   = tag_q.pop_front();
                check(t, int'($signed(product)), e);
                check("R6 latency", cyc - iss, 3);
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        sample_in = '0;
        coef_in   = '0;
        // R7: reset state, even with in_valid driven high
        repeat (2) @(negedge clk);
        in_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R7 out_valid", int'(out_valid), 0);
            check("R7 product", int'(product), 0);
        end
        in_valid = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R8: worked example, literal expected value
        issue(10'h122, 7, "R8");
        // R3: all stages skipped
        issue(10'b0001001001, -32, "R3");
        repeat (4) idle();
        check("R6 drained", exp_q.size(), 0);

        // exhaustive sweep: every code with every sample, back to back
        for (int code = 0; code < 1024; code++) begin
            for (int x = -(1 << (XW - 1)); x < (1 << (XW - 1)); x++) begin
                issue(code, x, "");
                if (x == 0 && code[0]) idle();
            end
        end
        in_valid = 1'b0;
        repeat (5) idle();
        check("R6 all results returned", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule